// File: doc/BRIEF.md
# Serial Event Frame Decoder with Synapse Row Matching

This block sits at the end of one serial event lane. The lane carries short frames, each announcing that one of 64 source neurons has fired. The receiver runs on a sampling clock that splits every frame into sixteen bins and finds the frame boundaries by counting those bins. Each bit lasts two bins and is taken from the second of them. Until the lane has been trained with a few frames that carry address zero, no traffic is accepted. After that, every well-formed frame yields a 6-bit source address.

The address is then split in two. The two high bits are compared with a programmable pattern on each strobe line, and every line whose pattern matches fires. Each synapse in the row is wired to one fixed strobe line and holds its own 4-bit address. A synapse responds only when its line fired and its address equals the low four address bits. A responding synapse emits a pulse that lasts a programmable number of clock cycles. While the pulse is high it also drives its stored 4-bit weight and a bit that picks one of two summing lines.

The decoded event output is a single-cycle `evt_valid` with no ready input. A serial lane cannot be held off, so the block applies no back-pressure and every consumer must accept the event in the cycle it appears. Configuration is a plain write port: word 0 holds the strobe patterns, word 1 holds the pulse length, and word 2+i holds the settings of synapse i.

Top module: `event_frame_decoder`

## Requirements
- R1: The line idles high. A frame is eight bits of two sample cycles each: a start bit of 0, six address bits with the most significant first, then a stop bit of 1. Each bit is taken in its second sample cycle. A new frame may begin in the cycle right after a stop bit, and level changes inside a frame never start a frame.
- R2: After reset `locked` is 0 and `err_count` is 0. `locked` rises once LOCK_FRAMES (default 3) well-formed frames with address 0 have arrived in a row, and it stays high until reset.
- R3: Before lock, no event is produced and no synapse pulses. A well-formed frame with a nonzero address raises `err_count` by one and restarts the training count.
- R4: A frame whose stop-bit sample is 0 is dropped, raises `err_count` by one and, before lock, restarts the training count. `err_count` saturates at its maximum value.
- R5: After lock, every well-formed frame raises `evt_valid` for exactly one cycle, with `evt_addr` equal to the received address. This happens on the first rising edge after the edge that captures the stop bit's second sample cycle.
- R6: Strobe line s fires for an event when `evt_addr[5:4]` equals the pattern in bits [2s+1:2s] of configuration word 0. Several lines may fire for one event.
- R7: Synapse i is attached to strobe line i mod NSTROBE. It pulses only if that line fired and bits [3:0] of configuration word 2+i equal `evt_addr[3:0]`.
- R8: The pulse starts on the clock edge after `evt_valid` and lasts exactly the number of cycles given in bits [5:0] of configuration word 1. A length of 0 produces no pulse.
- R9: While synapse i pulses, its weight field carries bits [7:4] of word 2+i and its line bit carries bit 8. Both fields are 0 when it is not pulsing. Both values are captured at the event, so a configuration write during a pulse does not change them.
- R10: An event that arrives while pulses are running restarts the pulse timer at the full length, and the set of pulsing synapses becomes that of the new event.
- R11: A low level lasting only one sample cycle (a start bit cut short) is dropped without an event and without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one tick per frame bin |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Oversampled serial event lane, idle high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CFG_AW (4) | Configuration word select |
| cfg_wdata | input | CFG_DW (9) | Configuration write data |
| locked | output | 1 | Lane trained and accepting events |
| err_count | output | ERR_W (8) | Saturating count of rejected frames |
| evt_valid | output | 1 | One-cycle decoded event strobe |
| evt_addr | output | 6 | Address of the last decoded event |
| syn_pulse | output | NSYN (8) | Per-synapse pulse |
| syn_weight | output | 4*NSYN (32) | Per-synapse weight, synapse i in bits [4i+3:4i] |
| syn_line | output | NSYN (8) | Per-synapse summing-line select during its pulse |

## Verification
A bin counter that slips by even one sample cycle shifts the address bits or misreads the stop bit. This shows up at `evt_addr` or `err_count` at the end of the same frame, within sixteen cycles. A training counter in the wrong state makes `locked` rise one frame early or late, or makes stray errors appear during training. A fault in the pulse timer or in the captured synapse state shows up as a wrong pulse width, a wrong set of pulsing synapses or a weight that changes mid-pulse. Each of these is visible within one pulse length of the event.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W         = 6;
  localparam int HI_W           = 2;
  localparam int LO_W           = ADDR_W - HI_W;
  localparam int W_W            = 4;
  localparam int BINS_PER_BIT   = 2;
  localparam int BITS_PER_FRAME = 8;
  localparam int BINS_PER_FRAME = BINS_PER_BIT * BITS_PER_FRAME;
  localparam int BIN_W          = $clog2(BINS_PER_FRAME);
  localparam int BIT_W          = $clog2(BITS_PER_FRAME);

  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_e;

  typedef struct packed {
    logic            sel;
    logic [W_W-1:0]  weight;
    logic [LO_W-1:0] addr;
  } syn_cfg_t;

  localparam int SYN_CFG_W = $bits(syn_cfg_t);
endpackage

// File: rtl/evt_frame_rx.sv
module evt_frame_rx
  import evt_pkg::*;
#(
  parameter int LOCK_FRAMES = 3,
  parameter int ERR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic              evt_valid,
  output logic [ADDR_W-1:0] evt_addr,
  output logic              locked,
  output logic [ERR_W-1:0]  err_count
);
  localparam int LCW = $clog2(LOCK_FRAMES + 1);
  localparam logic [BIT_W-1:0] STOP_IDX = BIT_W'(BITS_PER_FRAME - 1);

  rx_state_e         st;
  logic              s_q, s_prev;
  logic [BIN_W-1:0]  bin;
  logic [ADDR_W-1:0] shreg;
  logic [LCW-1:0]    lock_cnt;

  logic [BIT_W-1:0] bit_idx;
  logic             centre, frame_end, start_bad, data_smp;
  logic             good, stop_bad, train_ok, train_bad, err_bump;

  // Bit index and the sampling bin inside that bit.
  assign bit_idx   = bin[BIN_W-1:1];
  assign centre    = bin[0];
  assign frame_end = (st == RX_BUSY) && centre && (bit_idx == STOP_IDX);
  assign start_bad = (st == RX_BUSY) && centre && (bit_idx == '0) && s_q;
  assign data_smp  = (st == RX_BUSY) && centre && (bit_idx != '0) && (bit_idx != STOP_IDX);
  assign good      = frame_end && s_q;
  assign stop_bad  = frame_end && !s_q;
  assign train_ok  = good && !locked && (shreg == '0);
  assign train_bad = good && !locked && (shreg != '0);
  assign err_bump  = stop_bad || train_bad;

  // Bin counting, frame delimiting and address shifting.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      bin    <= '0;
      s_q    <= 1'b1;
      s_prev <= 1'b1;
      shreg  <= '0;
    end else begin
      s_q    <= ser_in;
      s_prev <= s_q;
      if (st == RX_IDLE) begin
        if (s_prev && !s_q) begin
          st  <= RX_BUSY;
          bin <= BIN_W'(1);
        end
      end else begin
        bin <= bin + 1'b1;
        if (start_bad || frame_end) st <= RX_IDLE;
      end
      if (data_smp) shreg <= {shreg[ADDR_W-2:0], s_q};
    end
  end

  // Event output, only once trained.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_addr  <= '0;
    end else begin
      evt_valid <= good && locked;
      if (good && locked) evt_addr <= shreg;
    end
  end

  // Training sequence on consecutive zero-address frames.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      lock_cnt <= '0;
    end else if (train_ok) begin
      if (lock_cnt == LCW'(LOCK_FRAMES - 1)) begin
        locked   <= 1'b1;
        lock_cnt <= '0;
      end else begin
        lock_cnt <= lock_cnt + 1'b1;
      end
    end else if (err_bump && !locked) begin
      lock_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          err_count <= '0;
    else if (err_bump && err_count != '1) err_count <= err_count + 1'b1;
  end

  p_evt_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> locked);
  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  p_err_nodrop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> err_count >= $past(err_count));
  p_err_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == '1) |=> (err_count == '1));
  p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
endmodule

// File: rtl/evt_strobe_sel.sv
module evt_strobe_sel
  import evt_pkg::*;
#(
  parameter int NSTROBE = 4
) (
  input  logic [NSTROBE*HI_W-1:0] patterns,
  input  logic [HI_W-1:0]         hi_addr,
  output logic [NSTROBE-1:0]      hit
);
  for (genvar s = 0; s < NSTROBE; s++) begin : g_line
    assign hit[s] = (patterns[s*HI_W +: HI_W] == hi_addr);
  end
endmodule

// File: rtl/evt_pulse_timer.sv
module evt_pulse_timer #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= len;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len != '0) |=> active);
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len == '0) |=> !active);
endmodule

// File: rtl/evt_syn_cell.sv
module evt_syn_cell
  import evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            line_hit,
  input  logic [LO_W-1:0] lo_addr,
  input  syn_cfg_t        cfg,
  input  logic            active,
  output logic            pulse,
  output logic [W_W-1:0]  weight,
  output logic            line_sel
);
  logic           hit_q, sel_q;
  logic [W_W-1:0] w_q;

  // Match and settings are captured when the event arrives.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      w_q   <= '0;
      sel_q <= 1'b0;
    end else if (start) begin
      hit_q <= line_hit && (cfg.addr == lo_addr);
      w_q   <= cfg.weight;
      sel_q <= cfg.sel;
    end
  end

  assign pulse    = hit_q && active;
  assign weight   = pulse ? w_q : '0;
  assign line_sel = pulse && sel_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !start) |=> (!pulse || ($stable(weight) && $stable(line_sel))));
endmodule

// File: rtl/event_frame_decoder.sv
module event_frame_decoder
  import evt_pkg::*;
#(
  parameter int NSYN        = 8,
  parameter int NSTROBE     = 4,
  parameter int LEN_W       = 6,
  parameter int ERR_W       = 8,
  parameter int LOCK_FRAMES = 3,
  localparam int PAT_W  = NSTROBE * HI_W,
  localparam int CFG_AW = $clog2(NSYN + 2),
  localparam int CFG_DW = (PAT_W > LEN_W)
                          ? ((PAT_W > SYN_CFG_W) ? PAT_W : SYN_CFG_W)
                          : ((LEN_W > SYN_CFG_W) ? LEN_W : SYN_CFG_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  output logic                 locked,
  output logic [ERR_W-1:0]     err_count,
  output logic                 evt_valid,
  output logic [ADDR_W-1:0]    evt_addr,
  output logic [NSYN-1:0]      syn_pulse,
  output logic [NSYN*W_W-1:0]  syn_weight,
  output logic [NSYN-1:0]      syn_line
);
  logic [PAT_W-1:0]   pat_q;
  logic [LEN_W-1:0]   len_q;
  logic [NSTROBE-1:0] line_hit;
  logic               active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q <= '0;
      len_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(0)) pat_q <= cfg_wdata[PAT_W-1:0];
      if (cfg_addr == CFG_AW'(1)) len_q <= cfg_wdata[LEN_W-1:0];
    end
  end

  evt_frame_rx #(.LOCK_FRAMES(LOCK_FRAMES), .ERR_W(ERR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .evt_valid(evt_valid), .evt_addr(evt_addr),
    .locked(locked), .err_count(err_count)
  );

  evt_strobe_sel #(.NSTROBE(NSTROBE)) u_sel (
    .patterns(pat_q), .hi_addr(evt_addr[ADDR_W-1:LO_W]), .hit(line_hit)
  );

  evt_pulse_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(evt_valid), .len(len_q), .active(active)
  );

  for (genvar i = 0; i < NSYN; i++) begin : g_syn
    syn_cfg_t cfg_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                                     cfg_q <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(i + 2)) cfg_q <= cfg_wdata[SYN_CFG_W-1:0];
    end

    evt_syn_cell u_cell (
      .clk(clk), .rst_n(rst_n), .start(evt_valid),
      .line_hit(line_hit[i % NSTROBE]), .lo_addr(evt_addr[LO_W-1:0]),
      .cfg(cfg_q), .active(active),
      .pulse(syn_pulse[i]), .weight(syn_weight[i*W_W +: W_W]),
      .line_sel(syn_line[i])
    );
  end

  p_quiet_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (syn_pulse == '0));
  p_pulse_needs_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_pulse != '0) |-> active);
endmodule

// File: tb/sim_event_frame_decoder.sv
`timescale 1ns/1ps
module sim_event_frame_decoder;
  localparam int NSYN = 8;
  localparam int NSTROBE = 4;

  logic       clk = 1'b0, rst_n = 1'b0, ser_in = 1'b1, cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [8:0] cfg_wdata = '0;
  logic       locked, evt_valid;
  logic [7:0] err_count;
  logic [5:0] evt_addr;
  logic [NSYN-1:0]   syn_pulse, syn_line;
  logic [NSYN*4-1:0] syn_weight;

  event_frame_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .locked(locked),
    .err_count(err_count), .evt_valid(evt_valid), .evt_addr(evt_addr),
    .syn_pulse(syn_pulse), .syn_weight(syn_weight), .syn_line(syn_line)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, evt_seen = 0;
  bit done = 0;
  logic [5:0] last_addr = '0, prev_addr = '0;
  int pat[NSTROBE] = '{1, 2, 1, 3};
  int sp_addr[NSYN] = '{3, 3, 3, 9, 5, 0, 3, 3};
  int sp_w[NSYN]    = '{1, 2, 3, 4, 5, 6, 7, 8};
  int sp_sel[NSYN]  = '{0, 1, 0, 1, 0, 1, 0, 1};
  int slen = 0;

  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      evt_seen++;
      prev_addr = last_addr;
      last_addr = evt_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ser_in = 1'b1;
    end
  endtask

  task automatic send_frame(input logic [5:0] a, input bit stop_ok);
    for (int b = 0; b < 8; b++)
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        ser_in = (b == 0) ? 1'b0 : (b == 7) ? stop_ok : a[6-b];
      end
  endtask

  task automatic cfg_write(input logic [3:0] ad, input logic [8:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_len(input int n);
    slen = n;
    cfg_write(4'd1, 9'(n));
  endtask

  function automatic bit exp_hit(input logic [5:0] a, input int i);
    return slen != 0 && pat[i % NSTROBE] == int'(a[5:4]) && sp_addr[i] == int'(a[3:0]);
  endfunction

  // Watch one event already sent: timing, address, per-synapse pulses and fields.
  task automatic observe(input logic [5:0] a, input string tag);
    int cnt[NSYN];
    int evk = 0, wbad = 0;
    for (int i = 0; i < NSYN; i++) cnt[i] = 0;
    for (int k = 1; k <= slen + 6; k++) begin
      @(negedge clk);
      ser_in = 1'b1;
      if (evt_valid && evk == 0) evk = k;
      for (int i = 0; i < NSYN; i++) begin
        if (syn_pulse[i]) begin
          if (k >= 3) cnt[i]++;
          if (int'(syn_weight[i*4 +: 4]) != sp_w[i] || int'(syn_line[i]) != sp_sel[i]) wbad++;
        end else if (syn_weight[i*4 +: 4] != 4'd0 || syn_line[i] != 1'b0) wbad++;
      end
    end
    check({"R5 event timing ", tag}, evk, 2);
    check({"R5 event address ", tag}, last_addr, a);
    for (int i = 0; i < NSYN; i++)
      check($sformatf("R7 R8 syn%0d pulse cycles %s", i, tag), cnt[i], exp_hit(a, i) ? slen : 0);
    check({"R9 weight and line fields ", tag}, wbad, 0);
  endtask

  task automatic t_reset;
    check("R2 reset locked", locked, 0);
    check("R2 reset err_count", err_count, 0);
    check("R2 reset pulses", syn_pulse, 0);
  endtask

  task automatic t_prelock;
    send_frame(6'h15, 1); idle(4);
    check("R3 nonzero frame before lock is an error", err_count, 1);
    send_frame(6'h00, 1); send_frame(6'h00, 1);
    send_frame(6'h01, 1); idle(4);
    check("R3 nonzero frame restarts training", err_count, 2);
    send_frame(6'h00, 1); send_frame(6'h00, 1); idle(4);
    check("R3 still unlocked after two", locked, 0);
    send_frame(6'h00, 0); idle(4);
    check("R4 missing stop before lock", err_count, 3);
    check("R4 training restarted by bad stop", locked, 0);
  endtask

  task automatic t_lock;
    send_frame(6'h00, 1); send_frame(6'h00, 1); idle(4);
    check("R2 not locked after two frames", locked, 0);
    send_frame(6'h00, 1); idle(4);
    check("R2 locked after three frames", locked, 1);
    check("R3 no events during training", evt_seen, 0);
    check("R3 no pulses during training", syn_pulse, 0);
  endtask

  task automatic t_config;
    logic [8:0] w = '0;
    for (int s = 0; s < NSTROBE; s++) w[2*s +: 2] = 2'(pat[s]);
    cfg_write(4'd0, w);
    for (int i = 0; i < NSYN; i++)
      cfg_write(4'(2 + i), {1'(sp_sel[i]), 4'(sp_w[i]), 4'(sp_addr[i])});
    set_len(4);
  endtask

  task automatic t_decode;
    send_frame(6'h13, 1); observe(6'h13, "R6 two lines fire");
    send_frame(6'h33, 1); observe(6'h33, "line3");
    send_frame(6'h23, 1); observe(6'h23, "line1");
    send_frame(6'h03, 1); observe(6'h03, "no line");
    send_frame(6'h15, 1); observe(6'h15, "low address 5");
  endtask

  task automatic t_lengths;
    set_len(1); send_frame(6'h13, 1); observe(6'h13, "len1");
    set_len(0); send_frame(6'h13, 1); observe(6'h13, "R8 len0");
    set_len(9); send_frame(6'h13, 1); observe(6'h13, "len9");
  endtask

  task automatic t_midcfg;
    int wbad = 0, c0 = 0;
    set_len(8);
    send_frame(6'h13, 1);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      ser_in = 1'b1;
      cfg_we = (k == 4);
      cfg_addr = 4'd2;
      cfg_wdata = {1'b1, 4'd15, 4'd3};
      if (syn_pulse[0]) begin
        c0++;
        if (syn_weight[3:0] != 4'd1 || syn_line[0] != 1'b0) wbad++;
      end
    end
    cfg_we = 1'b0;
    check("R9 captured fields during mid-pulse write", wbad, 0);
    check("R9 pulse length unaffected", c0, 8);
    sp_w[0] = 15; sp_sel[0] = 1;
    send_frame(6'h13, 1); observe(6'h13, "R9 new weight used");
  endtask

  task automatic t_retrig;
    set_len(40);
    send_frame(6'h13, 1);
    send_frame(6'h33, 1);
    observe(6'h33, "R10 retrigger");
    set_len(4);
  endtask

  task automatic t_badstop;
    int e0 = err_count, v0 = evt_seen;
    send_frame(6'h13, 0); idle(4);
    check("R4 bad stop counted after lock", err_count, e0 + 1);
    check("R4 bad stop gives no event", evt_seen, v0);
  endtask

  task automatic t_glitch;
    int e0 = err_count, v0 = evt_seen;
    @(negedge clk); ser_in = 1'b0;
    @(negedge clk); ser_in = 1'b1;
    idle(20);
    check("R11 short start no error", err_count, e0);
    check("R11 short start no event", evt_seen, v0);
    send_frame(6'h23, 1); observe(6'h23, "R11 after glitch");
  endtask

  task automatic t_b2b;
    int v0 = evt_seen;
    send_frame(6'h2A, 1);
    send_frame(6'h15, 1);
    idle(6);
    check("R1 back-to-back count", evt_seen, v0 + 2);
    check("R1 first frame address", prev_addr, 6'h2A);
    check("R1 second frame address", last_addr, 6'h15);
  endtask

  task automatic t_saturate;
    for (int n = 0; n < 260; n++) begin
      send_frame(6'h00, 0);
      idle(1);
    end
    idle(3);
    check("R4 err_count saturates", err_count, 255);
    check("R4 lock kept through errors", locked, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prelock;
    t_lock;
    t_config;
    t_decode;
    t_lengths;
    t_midcfg;
    t_retrig;
    t_badstop;
    t_glitch;
    t_b2b;
    t_saturate;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule